// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This block stands in for the read side of a byte-wide parallel NOR flash while an internal program or erase job runs. It holds a small byte array, accepts a program strobe (address plus data) or an erase strobe (a mask of sectors), and runs each job on a cycle counter in place of real cell timing. While a job is active, a host read that hits the job's target returns a polling status in bit 7 instead of array data. Reads that miss the target return plain array contents.

The status follows the inverse-then-true rule. While a byte is being programmed, bit 7 reads as the complement of the bit being written. While sectors are erasing, bit 7 reads 0. Once the job is finished, bit 7 reads the true value, which is 1 after an erase. An erase can be suspended. While suspended, selected sectors poll as 1, and a byte outside those sectors may be programmed before the erase resumes. Jobs aimed only at locked sectors do not change the array. They hold the status for a fixed window derived from the clock rate: 2 µs for a program and 100 µs for an erase.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, `busy` is 0 and `rd_data` is 0x00. Every array byte reads 0xFF.
- R2: A `prog_go` accepted while idle raises `busy` for exactly PROG_CYC cycles. After that, the addressed byte holds its old value ANDed with `prog_data`.
- R3: A read at the program address while a program runs returns bit 7 = NOT `prog_data[7]` and bits 6:0 from the array. Reads at other addresses return array data.
- R4: A program whose sector has its `sect_lock` bit set keeps `busy` high for 2*CLK_MHZ cycles, polls as in R3, and leaves the array unchanged.
- R5: An accepted `erase_go` keeps `busy` high for ERASE_CYC cycles. Reads inside any sector selected in `erase_sel` return bit 7 = 0 during this time. Afterwards every byte of each selected, unlocked sector reads 0xFF. The sector of an address is its top SECT_W bits.
- R6: Selected sectors that are locked keep their contents through an erase.
- R7: If every selected sector is locked, `busy` stays high for 100*CLK_MHZ cycles and no byte changes.
- R8: `susp_req` during a running erase, outside the locked-only window, drops `busy` on the next cycle. While suspended, reads inside selected sectors return bit 7 = 1. After `resume_req`, the erase continues, and its busy cycles before and after the suspension add up to ERASE_CYC. `susp_req` during a locked-only erase window is ignored.
- R9: While suspended, a program to a sector outside the erase selection runs as in R2 and R3. A program to a selected sector is ignored.
- R10: `prog_go` and `erase_go` are ignored while `busy` is high.
- R11: `rd_data` is registered. It updates on the clock after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_go | input | 1 | Program command completed (one-cycle strobe) |
| prog_addr | input | ADDR_W | Byte address to program |
| prog_data | input | 8 | Byte to program |
| erase_go | input | 1 | Erase command completed (one-cycle strobe) |
| erase_sel | input | 2**SECT_W | Sectors chosen for erase |
| sect_lock | input | 2**SECT_W | Per-sector write lock |
| susp_req | input | 1 | Suspend the running erase |
| resume_req | input | 1 | Resume a suspended erase |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Read result, array byte or status |
| busy | output | 1 | High while a job or lock window runs |

## Verification
The assertions assume that the strobes are single-cycle pulses and that `sect_lock` does not change while a job is in flight. They also assume that `prog_data`, `erase_sel` and the addresses are stable whenever their strobe is high. The stimulus meets these conditions in three ways. It changes inputs only on the falling clock edge. It raises every strobe for exactly one cycle. It sets the lock mask before each job and leaves it unchanged until `busy` has fallen and the bench has read back the array.

// File: rtl/flash_poll_status.sv
module flash_poll_status #(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int CLK_MHZ   = 1,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_go,
  input  logic [ADDR_W-1:0]       prog_addr,
  input  logic [7:0]              prog_data,
  input  logic                    erase_go,
  input  logic [(1<<SECT_W)-1:0]  erase_sel,
  input  logic [(1<<SECT_W)-1:0]  sect_lock,
  input  logic                    susp_req,
  input  logic                    resume_req,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic                    busy
);
  localparam int NSECT     = 1 << SECT_W;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PLOCK_CYC = 2 * CLK_MHZ;
  localparam int ELOCK_CYC = 100 * CLK_MHZ;
  localparam int PMAX      = PROG_CYC > PLOCK_CYC ? PROG_CYC : PLOCK_CYC;
  localparam int EMAX      = ERASE_CYC > ELOCK_CYC ? ERASE_CYC : ELOCK_CYC;
  localparam int CMAX      = PMAX > EMAX ? PMAX : EMAX;
  localparam int CW        = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_SUSP, S_SPROG} st_t;

  function automatic logic [SECT_W-1:0] sec_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  st_t              st;
  logic [7:0]       mem [DEPTH];
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]       p_data;
  logic             p_lock;
  logic [NSECT-1:0] e_sel, e_live;
  logic             e_lock;
  logic [CW-1:0]    p_cnt, e_cnt;

  wire             pg_locked = sect_lock[sec_of(prog_addr)];
  wire [NSECT-1:0] sel_live  = erase_sel & ~sect_lock;
  wire             p_run     = (st == S_PROG) || (st == S_SPROG);
  wire             p_done    = p_run && (p_cnt == CW'(1));
  wire             e_done    = (st == S_ERASE) && (e_cnt == CW'(1));

  assign busy = (st == S_PROG) || (st == S_ERASE) || (st == S_SPROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      p_addr <= '0;
      p_data <= '0;
      p_lock <= 1'b0;
      p_cnt  <= '0;
      e_sel  <= '0;
      e_live <= '0;
      e_lock <= 1'b0;
      e_cnt  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (prog_go) begin
            st     <= S_PROG;
            p_addr <= prog_addr;
            p_data <= prog_data;
            p_lock <= pg_locked;
            p_cnt  <= pg_locked ? CW'(PLOCK_CYC) : CW'(PROG_CYC);
          end else if (erase_go) begin
            st     <= S_ERASE;
            e_sel  <= erase_sel;
            e_live <= sel_live;
            e_lock <= (sel_live == '0);
            e_cnt  <= (sel_live == '0) ? CW'(ELOCK_CYC) : CW'(ERASE_CYC);
          end
        S_PROG:
          if (p_done) st <= S_IDLE;
          else        p_cnt <= p_cnt - CW'(1);
        S_ERASE:
          if (e_done) st <= S_IDLE;
          else begin
            e_cnt <= e_cnt - CW'(1);
            if (susp_req && !e_lock) st <= S_SUSP;
          end
        S_SUSP:
          if (resume_req) st <= S_ERASE;
          else if (prog_go && !e_sel[sec_of(prog_addr)]) begin
            st     <= S_SPROG;
            p_addr <= prog_addr;
            p_data <= prog_data;
            p_lock <= pg_locked;
            p_cnt  <= pg_locked ? CW'(PLOCK_CYC) : CW'(PROG_CYC);
          end
        S_SPROG:
          if (p_done) st <= S_SUSP;
          else        p_cnt <= p_cnt - CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (p_done && !p_lock) mem[p_addr] <= mem[p_addr] & p_data;
      if (e_done)
        for (int i = 0; i < DEPTH; i++)
          if (e_live[sec_of(ADDR_W'(i))]) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 8'h00;
    else if (rd_en) begin
      if (p_run && rd_addr == p_addr)
        rd_data <= {~p_data[7], mem[rd_addr][6:0]};
      else if (st == S_ERASE && e_sel[sec_of(rd_addr)])
        rd_data <= {1'b0, mem[rd_addr][6:0]};
      else if ((st == S_SUSP || st == S_SPROG) && e_sel[sec_of(rd_addr)])
        rd_data <= {1'b1, mem[rd_addr][6:0]};
      else
        rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/flash_poll_status_chk.sv
module flash_poll_status_chk #(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   prog_go,
  input logic                   rd_en,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [7:0]             rd_data,
  input logic [2:0]             st,
  input logic [ADDR_W-1:0]      p_addr,
  input logic [7:0]             p_data,
  input logic [(1<<SECT_W)-1:0] e_sel
);
  localparam logic [2:0] K_PROG  = 3'd1;
  localparam logic [2:0] K_ERASE = 3'd2;
  localparam logic [2:0] K_SUSP  = 3'd3;

  wire [SECT_W-1:0] rsec = rd_addr[ADDR_W-1 -: SECT_W];

  // R3
  prog_poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == K_PROG && rd_addr == p_addr) |=> (rd_data[7] != $past(p_data[7])));

  // R5
  erase_poll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == K_ERASE && e_sel[rsec]) |=> !rd_data[7]);

  // R8
  susp_poll_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == K_SUSP && e_sel[rsec]) |=> rd_data[7]);

  // R10
  busy_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_go) |=> $stable(p_addr));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind flash_poll_status flash_poll_status_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .prog_go(prog_go), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .st(st), .p_addr(p_addr),
  .p_data(p_data), .e_sel(e_sel)
);

// File: tb/flash_poll_status_bench.sv
module flash_poll_status_bench;
  localparam int PERIOD = 10;
  localparam int AW = 6, SW = 2, MHZ = 1, PC = 6, EC = 30;

  logic clk = 0, rst_n = 0;
  logic prog_go = 0, erase_go = 0, susp_req = 0, resume_req = 0, rd_en = 0;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic [7:0] prog_data = '0, rd_data;
  logic [3:0] erase_sel = '0, sect_lock = '0;
  logic busy;

  flash_poll_status #(.ADDR_W(AW), .SECT_W(SW), .CLK_MHZ(MHZ), .PROG_CYC(PC), .ERASE_CYC(EC))
    u_flash_poll_status (.clk, .rst_n, .prog_go, .prog_addr, .prog_data, .erase_go,
    .erase_sel, .sect_lock, .susp_req, .resume_req, .rd_en, .rd_addr, .rd_data, .busy);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, runlen = 0, last_run = 0;
  logic [7:0] ref_mem [64];

  always @(negedge clk)
    if (busy) runlen++;
    else if (runlen != 0) begin last_run = runlen; runlen = 0; end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    rd_addr = a; rd_en = 1; @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic pprog(input logic [AW-1:0] a, input logic [7:0] d);
    prog_addr = a; prog_data = d; prog_go = 1; @(negedge clk); prog_go = 0;
  endtask

  task automatic perase(input logic [3:0] s);
    erase_sel = s; erase_go = 1; @(negedge clk); erase_go = 0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 64; i++) begin
      rd(AW'(i), v);
      chk(tag, v, ref_mem[i]);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, held;
    int first;
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 rd_data", rd_data, 0);
    sweep("R1 array");

    for (int i = 0; i < 13; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'(i * 5 + 3);
      d = 8'((i * 73 + 29) & 255);
      pprog(a, d);
      rd(a, v);
      chk("R3 poll at target", v, {~d[7], ref_mem[a][6:0]});
      rd(a ^ 6'h01, v);
      chk("R3 other address", v, ref_mem[a ^ 6'h01]);
      pprog(AW'(a + 32), 8'h00);
      perase(4'b1111);
      wait_idle();
      chk("R2 R10 busy length", last_run, PC);
      ref_mem[a] = ref_mem[a] & d;
      rd(a, v);
      chk("R3 true after done", v, ref_mem[a]);
    end
    sweep("R2 R10 array");

    sect_lock = 4'b0100;
    @(negedge clk);
    pprog(6'h25, 8'h80);
    rd(6'h25, v);
    chk("R4 locked poll", v, {1'b0, ref_mem[6'h25][6:0]});
    wait_idle();
    chk("R4 lock window", last_run, 2 * MHZ);
    rd(6'h25, v);
    chk("R4 unchanged", v, ref_mem[6'h25]);

    sect_lock = 4'b0010;
    @(negedge clk);
    perase(4'b0011);
    rd(6'h03, v);
    chk("R5 poll sector0", v, {1'b0, ref_mem[6'h03][6:0]});
    rd(6'h13, v);
    chk("R5 poll locked selected", v, {1'b0, ref_mem[6'h13][6:0]});
    rd(6'h33, v);
    chk("R5 unselected", v, ref_mem[6'h33]);
    wait_idle();
    chk("R5 busy length", last_run, EC);
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    sweep("R5 R6 array");

    sect_lock = 4'b0100;
    @(negedge clk);
    perase(4'b0100);
    rd(6'h25, v);
    chk("R7 poll", v, {1'b0, ref_mem[6'h25][6:0]});
    susp_req = 1; @(negedge clk); susp_req = 0;
    chk("R8 suspend ignored in window", busy, 1);
    wait_idle();
    chk("R7 window", last_run, 100 * MHZ);
    sweep("R7 array");

    sect_lock = 4'b0000;
    @(negedge clk);
    perase(4'b0100);
    repeat (4) @(negedge clk);
    susp_req = 1; @(negedge clk); susp_req = 0;
    chk("R8 busy drops", busy, 0);
    @(negedge clk);
    first = last_run;
    rd(6'h2C, v);
    chk("R8 suspended poll", v, {1'b1, ref_mem[6'h2C][6:0]});
    pprog(6'h2A, 8'h00);
    chk("R9 selected ignored", busy, 0);
    pprog(6'h31, 8'h5A);
    rd(6'h31, v);
    chk("R9 poll in suspend", v, {1'b1, ref_mem[6'h31][6:0]});
    rd(6'h2C, v);
    chk("R8 poll during program", v, {1'b1, ref_mem[6'h2C][6:0]});
    wait_idle();
    chk("R9 busy length", last_run, PC);
    ref_mem[6'h31] = ref_mem[6'h31] & 8'h5A;
    rd(6'h31, v);
    chk("R9 true after done", v, ref_mem[6'h31]);
    resume_req = 1; @(negedge clk); resume_req = 0;
    wait_idle();
    chk("R8 total erase cycles", first + last_run, EC);
    for (int i = 32; i < 48; i++) ref_mem[i] = 8'hFF;
    sweep("R8 R9 array");

    rd(6'h31, v);
    held = v;
    repeat (3) @(negedge clk);
    chk("R11 hold", rd_data, held);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule